// File: doc/BRIEF.md
# Precomputation-Filtered Parallel CAM

This block is a content-addressable memory of `WORDS` entries, each `WIDTH` bits wide. Next to each entry it keeps a short tag and an invalid flag. The tag is the population count of the entry's data, held in `ceil(log2(WIDTH+2))` bits. When software writes an entry, the tag is computed and stored in the same cycle. When a search is issued, the same tag is computed from the search key.

A search runs in two stages. In the first stage, the key's tag is compared against the tag of every entry at once. In the second stage, only entries that passed the tag filter, and that are still valid, perform the full-width data compare. Every other entry is held at mismatch and does no data comparison. Because the tag filter removes most entries before the wide compare, most of the data comparisons are skipped.

The result gives a hit flag, the binary index of the matching entry, the per-entry match vector, and the per-entry vector of second-stage enables. The enable vector shows exactly which entries performed a full compare. Searches can be issued on consecutive cycles, and the block returns one result per cycle.

Top module: `pcam_top`

## Requirements
- R1: While reset is low and after it is released, every entry is invalid. `done_o`, `hit_o`, `match_idx_o`, `match_vec_o` and `cmp_en_o` are all zero. A search issued after reset reports no hit and no second-stage enables.
- R2: A write (`wr_en_i`) stores `wr_data_i` at `wr_addr_i` and marks that entry valid on the same clock edge. A later search with an equal key reports `hit_o`=1, `match_idx_o` equal to that address, and bit `address` set in `match_vec_o`.
- R3: For each search, bit i of `cmp_en_o` is 1 exactly when entry i is valid and the population count of its stored data equals the population count of the key.
- R4: Bit i of `match_vec_o` is 1 only when bit i of `cmp_en_o` is 1 and the stored data of entry i equals the key in all `WIDTH` bits.
- R5: `inv_en_i` marks the entry at `inv_addr_i` invalid. An invalid entry never appears in `cmp_en_o` or `match_vec_o`. When a write and an invalidate target the same address in the same cycle, the invalidate wins: the entry ends invalid, and the written data never matches.
- R6: A search sampled with `srch_start_i`=1 on clock edge k produces `done_o`=1 for exactly one cycle after edge k+1. `hit_o`, `match_idx_o`, `match_vec_o` and `cmp_en_o` hold the result of the last completed search until the next `done_o`.
- R7: When no entry matches, `hit_o`=0, `match_idx_o`=0 and `match_vec_o`=0.
- R8: When more than one entry matches, `match_idx_o` is the lowest matching index, and `match_vec_o` shows every matching entry.
- R9: A key whose population count equals that of a stored entry, but whose data differs, enables that entry in `cmp_en_o` but does not match it.
- R10: Searches issued on consecutive cycles each produce their own result on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | IW | Entry written |
| wr_data_i | input | WIDTH | Data written |
| inv_en_i | input | 1 | Invalidate strobe |
| inv_addr_i | input | IW | Entry invalidated |
| srch_start_i | input | 1 | Start a search with `srch_key_i` |
| srch_key_i | input | WIDTH | Search key |
| done_o | output | 1 | One-cycle pulse, result valid |
| hit_o | output | 1 | At least one entry matched |
| match_idx_o | output | IW | Lowest matching entry, 0 on miss |
| match_vec_o | output | WORDS | Per-entry match |
| cmp_en_o | output | WORDS | Per-entry second-stage enable |

## Verification
The stimulus is chosen to separate the two stages:
- **Filter only.** Keys that share a population count with several stored entries but differ in data show the filter admitting entries that the data compare then rejects.
- **No candidates.** Keys with a population count no stored entry has show that nothing is enabled.
- **Duplicates.** Stored duplicates separate the lowest-index choice from the full match vector.
- **Invalidation.** Invalidation, alone and together with a write to the same address, shows that invalid entries drop out of both stages.
- **Pipelining.** Back-to-back searches check that two results in flight do not mix.

A seeded random mix of writes, invalidates and searches, with keys drawn both from stored data and at random, covers the remaining cases.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
  function automatic int param_w(input int width);
    return $clog2(width + 2);
  endfunction
endpackage

// File: rtl/pcam_param_ext.sv
module pcam_param_ext #(
  parameter int WIDTH = 16,
  parameter int PW    = 5
) (
  input  logic [WIDTH-1:0] data_i,
  output logic [PW-1:0]    param_o
);
  always_comb begin
    param_o = '0;
    for (int i = 0; i < WIDTH; i++) param_o = param_o + PW'(data_i[i]);
  end
endmodule

// File: rtl/pcam_word.sv
module pcam_word #(
  parameter int WIDTH = 16,
  parameter int PW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             inv_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PW-1:0]    wr_param_i,
  input  logic [PW-1:0]    key_param_i,
  input  logic             s2_en_i,
  input  logic [WIDTH-1:0] s2_key_i,
  output logic             cand_o,
  output logic             en_o,
  output logic             hit_o
);
  logic [WIDTH-1:0] data_q;
  logic [PW-1:0]    param_q;
  logic             invalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      param_q   <= '0;
      invalid_q <= 1'b1;
    end else if (inv_i) begin
      invalid_q <= 1'b1;
    end else if (wr_i) begin
      data_q    <= wr_data_i;
      param_q   <= wr_param_i;
      invalid_q <= 1'b0;
    end
  end

  // stage 1: tag filter
  assign cand_o = !invalid_q && (param_q == key_param_i);
  // stage 2: wide compare only when enabled
  assign en_o   = s2_en_i && !invalid_q;
  assign hit_o  = en_o && (data_q == s2_key_i);

  // R5
  inv_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (!cand_o && !en_o && !hit_o));
endmodule

// File: rtl/pcam_prio_enc.sv
module pcam_prio_enc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pcam_top.sv
module pcam_top #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16,
  localparam int IW   = $clog2(WORDS),
  localparam int PW   = pcam_pkg::param_w(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             inv_en_i,
  input  logic [IW-1:0]    inv_addr_i,
  input  logic             srch_start_i,
  input  logic [WIDTH-1:0] srch_key_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [IW-1:0]    match_idx_o,
  output logic [WORDS-1:0] match_vec_o,
  output logic [WORDS-1:0] cmp_en_o
);
  logic [PW-1:0]    wr_param, key_param;
  logic [WORDS-1:0] cand, word_en, word_hit;
  logic             s1_vld_q;
  logic [WIDTH-1:0] s1_key_q;
  logic [WORDS-1:0] s1_en_q;
  logic             enc_found;
  logic [IW-1:0]    enc_idx;

  pcam_param_ext #(.WIDTH(WIDTH), .PW(PW)) u_wr_ext  (.data_i(wr_data_i),  .param_o(wr_param));
  pcam_param_ext #(.WIDTH(WIDTH), .PW(PW)) u_key_ext (.data_i(srch_key_i), .param_o(key_param));

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    pcam_word #(.WIDTH(WIDTH), .PW(PW)) u_word (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_en_i  && (wr_addr_i  == IW'(g))),
      .inv_i      (inv_en_i && (inv_addr_i == IW'(g))),
      .wr_data_i  (wr_data_i),
      .wr_param_i (wr_param),
      .key_param_i(key_param),
      .s2_en_i    (s1_en_q[g]),
      .s2_key_i   (s1_key_q),
      .cand_o     (cand[g]),
      .en_o       (word_en[g]),
      .hit_o      (word_hit[g])
    );
  end

  pcam_prio_enc #(.N(WORDS), .IW(IW)) u_enc (
    .req_i(word_hit), .found_o(enc_found), .idx_o(enc_idx));

  // stage 1 register: key and candidate set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_key_q <= '0;
      s1_en_q  <= '0;
    end else begin
      s1_vld_q <= srch_start_i;
      s1_en_q  <= srch_start_i ? cand : '0;
      if (srch_start_i) s1_key_q <= srch_key_i;
    end
  end

  // stage 2 register: result, held until next search completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      hit_o       <= 1'b0;
      match_idx_o <= '0;
      match_vec_o <= '0;
      cmp_en_o    <= '0;
    end else begin
      done_o <= s1_vld_q;
      if (s1_vld_q) begin
        hit_o       <= enc_found;
        match_idx_o <= enc_idx;
        match_vec_o <= word_hit;
        cmp_en_o    <= word_en;
      end
    end
  end

  // R4
  vec_in_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((match_vec_o & ~cmp_en_o) == '0));
  // R6
  start_s1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_start_i |=> s1_vld_q);
  // R6
  s1_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_q |=> done_o);
  // R6
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld_q |=> !done_o);
  // R6
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hit_o) && $stable(match_idx_o) && $stable(match_vec_o)));
  // R7
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (match_idx_o == '0 && match_vec_o == '0));
  // R8
  hit_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hit_o == (match_vec_o != '0)));
endmodule

// File: tb/pcam_top_tb.sv
`timescale 1ns/1ps
module pcam_top_tb;
  localparam int WORDS = 16;
  localparam int WIDTH = 16;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, inv_en = 1'b0, start = 1'b0;
  logic [IW-1:0] wr_addr = '0, inv_addr = '0;
  logic [WIDTH-1:0] wr_data = '0, key = '0;
  logic done, hit;
  logic [IW-1:0] idx;
  logic [WORDS-1:0] vec, en;

  int checks = 0;
  int fails  = 0;

  logic [WIDTH-1:0] mdl_data [WORDS];
  bit               mdl_vld  [WORDS];

  always #2.5 clk = ~clk;

  pcam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .inv_en_i(inv_en), .inv_addr_i(inv_addr),
    .srch_start_i(start), .srch_key_i(key),
    .done_o(done), .hit_o(hit), .match_idx_o(idx),
    .match_vec_o(vec), .cmp_en_o(en));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pc(input logic [WIDTH-1:0] d);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) n += int'(d[i]);
    return n;
  endfunction

  function automatic void model(input logic [WIDTH-1:0] k,
                                output logic [WORDS-1:0] e_en, output logic [WORDS-1:0] e_vec,
                                output bit e_hit, output logic [IW-1:0] e_idx);
    e_en = '0; e_vec = '0; e_hit = 0; e_idx = '0;
    for (int i = 0; i < WORDS; i++) begin
      e_en[i]  = mdl_vld[i] && (pc(mdl_data[i]) == pc(k));
      e_vec[i] = e_en[i] && (mdl_data[i] == k);
    end
    for (int i = WORDS - 1; i >= 0; i--)
      if (e_vec[i]) begin e_hit = 1; e_idx = IW'(i); end
  endfunction

  task automatic check_result(input logic [WIDTH-1:0] k, input string req);
    logic [WORDS-1:0] e_en, e_vec; bit e_hit; logic [IW-1:0] e_idx;
    model(k, e_en, e_vec, e_hit, e_idx);
    chk(done == 1'b1, "R6", "done", 64'(done), 64'd1);
    chk(en == e_en, "R3", "cmp_en", 64'(en), 64'(e_en));
    chk(vec == e_vec, e_hit ? "R4" : "R7", "match_vec", 64'(vec), 64'(e_vec));
    chk(hit == e_hit, req, "hit", 64'(hit), 64'(e_hit));
    chk(idx == e_idx, e_hit ? "R8" : "R7", "idx", 64'(idx), 64'(e_idx));
  endtask

  task automatic search(input logic [WIDTH-1:0] k, input string req);
    @(negedge clk); start = 1'b1; key = k;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R6", "done early", 64'(done), 64'd0);
    @(negedge clk);
    check_result(k, req);
  endtask

  task automatic write(input logic [IW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    mdl_data[a] = d; mdl_vld[a] = 1;
  endtask

  task automatic invalidate(input logic [IW-1:0] a);
    @(negedge clk); inv_en = 1'b1; inv_addr = a;
    @(negedge clk); inv_en = 1'b0;
    mdl_vld[a] = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [IW-1:0] h_idx;
    bit h_hit;
    seed = $urandom(32'd4242);
    for (int i = 0; i < WORDS; i++) begin mdl_data[i] = '0; mdl_vld[i] = 0; end

    // R1: reset state
    @(negedge clk);
    chk(done == 0 && hit == 0 && idx == 0 && vec == 0 && en == 0, "R1", "outputs in reset",
        64'({done, hit, idx, vec, en}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && hit == 0 && vec == 0 && en == 0, "R1", "outputs after reset",
        64'({done, hit, vec, en}), 64'd0);
    search(16'h0000, "R1");

    // R2, R3, R9: tag filter versus full compare
    write(4'd3, 16'h00F0);
    write(4'd9, 16'h0F00);
    write(4'd5, 16'hFFFF);
    search(16'h00F0, "R2");
    search(16'h0F00, "R2");
    search(16'h000F, "R9");
    chk(en == 16'h0208, "R9", "same-count enables", 64'(en), 64'h0208);
    search(16'h0FF0, "R7");
    search(16'hFFFF, "R2");

    // R8: duplicates, lowest index wins
    write(4'd12, 16'h00F0);
    search(16'h00F0, "R8");
    chk(vec == 16'h1008, "R8", "dup vector", 64'(vec), 64'h1008);
    write(4'd1, 16'h00F0);
    search(16'h00F0, "R8");
    chk(idx == 4'd1, "R8", "dup idx", 64'(idx), 64'd1);

    // R5: invalidate, and invalidate beating a write
    invalidate(4'd1);
    search(16'h00F0, "R5");
    chk(en[1] == 1'b0, "R5", "invalid not enabled", 64'(en[1]), 64'd0);
    @(negedge clk); wr_en = 1'b1; inv_en = 1'b1; wr_addr = 4'd3; inv_addr = 4'd3; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0; inv_en = 1'b0;
    mdl_vld[3] = 0;
    search(16'h1234, "R5");
    search(16'h00F0, "R5");
    chk(idx == 4'd12, "R5", "idx after inv", 64'(idx), 64'd12);

    // R6: result held, done pulses once
    h_hit = hit; h_idx = idx;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(done == 0 && hit == h_hit && idx == h_idx, "R6", "hold",
          64'({done, hit, idx}), 64'({1'b0, h_hit, h_idx}));
    end

    // R10: back-to-back searches
    @(negedge clk); start = 1'b1; key = 16'hFFFF;
    @(negedge clk); key = 16'h0F00;
    @(negedge clk); start = 1'b0;
    check_result(16'hFFFF, "R10");
    @(negedge clk);
    check_result(16'h0F00, "R10");
    @(negedge clk);
    chk(done == 1'b0, "R10", "done after pair", 64'(done), 64'd0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [IW-1:0] a;
      logic [WIDTH-1:0] d;
      op = int'($urandom_range(0, 9));
      a  = IW'($urandom_range(0, WORDS - 1));
      d  = WIDTH'($urandom);
      if ($urandom_range(0, 1) == 1) d = d & WIDTH'($urandom) & 16'h0FFF;
      if (op < 4) write(a, d);
      else if (op == 4) invalidate(a);
      else if (op < 8) search(mdl_data[a], "R2");
      else search(d, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule